// File: doc/BRIEF.md
# Fetch Program Counter Selector and Predictor

This block sits at the front of a five-stage in-order pipeline. It decides which address the fetch stage reads each cycle and guesses where the instruction after it will be. No single architectural program counter register exists. The fetch address is rebuilt every cycle from one of three candidates:

- the guess stored in the fetch register;
- the fall-through address of a conditional jump that the memory stage has found to be wrongly guessed;
- a return address that a return instruction carries out of write-back.

The guess is the jump target for any jump or call, and the address just past the current instruction in all other cases. All conditional jumps are therefore treated as taken.

The fetch stage feeds this block the class code, the constant field and the incremented address of the instruction it has just read. It receives the guess for the next cycle back from the block. Later stages report two things:
- whether the memory stage holds a conditional jump, and whether that jump's condition held, together with its fall-through address;
- whether a return is in write-back, together with the address it loaded.

The hazard control logic can freeze the fetch register with a stall input.

Top module: `fetch_pc_sel`

## Requirements
- R1: While reset is low, the fetch register is 0, so `fetch_pc` reads 0 when no override input is active.
- R2: With no correction and no return active, `fetch_pc` equals the address held in the fetch register.
- R3: When `m_cjmp` is 1 and `m_cnd` is 0 (a wrongly guessed jump), `fetch_pc` equals `m_fallthru` in the same cycle.
- R4: When `w_ret` is 1 and no wrongly guessed jump is present, `fetch_pc` equals `w_ret_addr` in the same cycle.
- R5: When a wrongly guessed jump and a return are present together, the jump correction wins and `fetch_pc` equals `m_fallthru`.
- R6: A conditional jump in memory whose condition held (`m_cjmp`=1, `m_cnd`=1) causes no override.
- R7: When `f_cls` is the jump code (default 7) or the call code (default 8), `pred_pc` equals `f_valc`.
- R8: For every other `f_cls` value, including the return code, `pred_pc` equals `f_valp`.
- R9: When `f_stall` is 0, the fetch register loads `pred_pc` at the rising clock edge.
- R10: When `f_stall` is 1, the fetch register keeps its value across the edge, and this holds even while an override is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_stall | input | 1 | Freeze the fetch register |
| f_cls | input | CLS_W | Class code of the instruction being fetched |
| f_valc | input | PC_W | Constant (target) field of the fetched instruction |
| f_valp | input | PC_W | Address following the fetched instruction |
| m_cjmp | input | 1 | Memory stage holds a conditional jump |
| m_cnd | input | 1 | Condition outcome of that jump |
| m_fallthru | input | PC_W | Fall-through address carried by that jump |
| w_ret | input | 1 | Write-back holds a return |
| w_ret_addr | input | PC_W | Return address loaded by that return |
| fetch_pc | output | PC_W | Address to fetch this cycle |
| pred_pc | output | PC_W | Guessed address for the next fetch |

## Verification
The selector is driven with each override alone, with both overrides together, and with a taken conditional jump that must not override. This sets the priority order apart from a plain "any override" mux. The guess is tried with the jump, call and return classes and with ordinary classes, including the all-ones code, so that a wrong class decode shows up as the wrong field.

Stalls are applied both with and without an active correction. This shows whether the stored guess is frozen, or whether it leaks the override address or the new guess into the register. Full-width addresses make sure the upper bits are carried through.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    SRC_GUESS = 2'd0,
    SRC_FIX   = 2'd1,
    SRC_RET   = 2'd2
  } fpc_src_e;

endpackage

// File: rtl/fpc_guess.sv
module fpc_guess #(
  parameter int unsigned PC_W     = 64,
  parameter int unsigned CLS_W    = 4,
  parameter int unsigned CLS_JUMP = 7,
  parameter int unsigned CLS_CALL = 8
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [PC_W-1:0]  valc,
  input  logic [PC_W-1:0]  valp,
  output logic [PC_W-1:0]  guess
);

  localparam logic [CLS_W-1:0] JumpCode = CLS_W'(CLS_JUMP);
  localparam logic [CLS_W-1:0] CallCode = CLS_W'(CLS_CALL);

  logic use_target;

  always_comb begin
    use_target = (cls == JumpCode) || (cls == CallCode);
    guess      = use_target ? valc : valp;
  end

endmodule

// File: rtl/fpc_override.sv
module fpc_override
  import fpc_pkg::*;
#(
  parameter int unsigned PC_W = 64
) (
  input  logic [PC_W-1:0] held,
  input  logic            m_cjmp,
  input  logic            m_cnd,
  input  logic [PC_W-1:0] m_fallthru,
  input  logic            w_ret,
  input  logic [PC_W-1:0] w_ret_addr,
  output fpc_src_e        src,
  output logic [PC_W-1:0] addr
);

  logic wrong_guess;

  always_comb begin
    wrong_guess = m_cjmp && !m_cnd;
    if (wrong_guess)  src = SRC_FIX;
    else if (w_ret)   src = SRC_RET;
    else              src = SRC_GUESS;
  end

  always_comb begin
    unique case (src)
      SRC_FIX: addr = m_fallthru;
      SRC_RET: addr = w_ret_addr;
      default: addr = held;
    endcase
  end

endmodule

// File: rtl/fpc_hold_reg.sv
module fpc_hold_reg #(
  parameter int unsigned PC_W     = 64,
  parameter logic [63:0] RESET_PC = 64'd0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);

  logic [PC_W-1:0] q_nxt;

  always_comb begin
    q_nxt = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_PC[PC_W-1:0];
    else        q <= q_nxt;
  end

endmodule

// File: rtl/fetch_pc_sel.sv
module fetch_pc_sel
  import fpc_pkg::*;
#(
  parameter int unsigned PC_W     = 64,
  parameter int unsigned CLS_W    = 4,
  parameter int unsigned CLS_JUMP = 7,
  parameter int unsigned CLS_CALL = 8,
  parameter logic [63:0] RESET_PC = 64'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_stall,
  input  logic [CLS_W-1:0] f_cls,
  input  logic [PC_W-1:0]  f_valc,
  input  logic [PC_W-1:0]  f_valp,
  input  logic             m_cjmp,
  input  logic             m_cnd,
  input  logic [PC_W-1:0]  m_fallthru,
  input  logic             w_ret,
  input  logic [PC_W-1:0]  w_ret_addr,
  output logic [PC_W-1:0]  fetch_pc,
  output logic [PC_W-1:0]  pred_pc
);

  logic [PC_W-1:0] f_q;
  logic            f_load;
  fpc_src_e        pick;

  always_comb begin
    f_load = !f_stall;
  end

  fpc_hold_reg #(
    .PC_W     (PC_W),
    .RESET_PC (RESET_PC)
  ) i_freg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (f_load),
    .d     (pred_pc),
    .q     (f_q)
  );

  fpc_override #(
    .PC_W (PC_W)
  ) i_ovr (
    .held       (f_q),
    .m_cjmp     (m_cjmp),
    .m_cnd      (m_cnd),
    .m_fallthru (m_fallthru),
    .w_ret      (w_ret),
    .w_ret_addr (w_ret_addr),
    .src        (pick),
    .addr       (fetch_pc)
  );

  fpc_guess #(
    .PC_W     (PC_W),
    .CLS_W    (CLS_W),
    .CLS_JUMP (CLS_JUMP),
    .CLS_CALL (CLS_CALL)
  ) i_guess (
    .cls   (f_cls),
    .valc  (f_valc),
    .valp  (f_valp),
    .guess (pred_pc)
  );

endmodule

// File: rtl/fetch_pc_sel_chk.sv
module fetch_pc_sel_chk #(
  parameter int unsigned PC_W     = 64,
  parameter int unsigned CLS_W    = 4,
  parameter int unsigned CLS_JUMP = 7,
  parameter int unsigned CLS_CALL = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             f_stall,
  input logic [CLS_W-1:0] f_cls,
  input logic [PC_W-1:0]  f_valc,
  input logic [PC_W-1:0]  f_valp,
  input logic             m_cjmp,
  input logic             m_cnd,
  input logic [PC_W-1:0]  m_fallthru,
  input logic             w_ret,
  input logic [PC_W-1:0]  w_ret_addr,
  input logic [PC_W-1:0]  fetch_pc,
  input logic [PC_W-1:0]  pred_pc,
  input logic [PC_W-1:0]  f_q
);

  a_r3_fix_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cjmp && !m_cnd) |-> fetch_pc == m_fallthru);

  a_r4_ret_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ret && !(m_cjmp && !m_cnd)) |-> fetch_pc == w_ret_addr);

  a_r2_held_guess: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_ret && !(m_cjmp && !m_cnd)) |-> fetch_pc == f_q);

  a_r7_target: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cls == CLS_W'(CLS_JUMP) || f_cls == CLS_W'(CLS_CALL)) |-> pred_pc == f_valc);

  a_r8_next_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cls != CLS_W'(CLS_JUMP) && f_cls != CLS_W'(CLS_CALL)) |-> pred_pc == f_valp);

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    !f_stall |=> f_q == $past(pred_pc));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    f_stall |=> $stable(f_q));

endmodule

bind fetch_pc_sel fetch_pc_sel_chk #(
  .PC_W     (PC_W),
  .CLS_W    (CLS_W),
  .CLS_JUMP (CLS_JUMP),
  .CLS_CALL (CLS_CALL)
) i_fetch_pc_sel_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .f_stall    (f_stall),
  .f_cls      (f_cls),
  .f_valc     (f_valc),
  .f_valp     (f_valp),
  .m_cjmp     (m_cjmp),
  .m_cnd      (m_cnd),
  .m_fallthru (m_fallthru),
  .w_ret      (w_ret),
  .w_ret_addr (w_ret_addr),
  .fetch_pc   (fetch_pc),
  .pred_pc    (pred_pc),
  .f_q        (f_q)
);

// File: tb/test_fetch_pc_sel.sv
module test_fetch_pc_sel;

  localparam int unsigned PC_W  = 64;
  localparam int unsigned CLS_W = 4;

  typedef struct packed {
    logic [3:0]  cls;
    logic [63:0] valc;
    logic [63:0] valp;
    logic        mj;
    logic        mc;
    logic [63:0] mf;
    logic        wr;
    logic [63:0] wa;
    logic        st;
    logic [63:0] ef;
    logic [63:0] ep;
  } vec_t;

  localparam int NV = 12;
  // Each row runs one cycle; ef/ep are the expected fetch_pc/pred_pc in that cycle.
  localparam vec_t TBL [NV] = '{
    '{4'd0, 64'h100, 64'h2,   1'b0,1'b0,64'h0,   1'b0,64'h0,   1'b0, 64'h0,    64'h2},    // R2 R8
    '{4'd7, 64'h40,  64'hB,   1'b0,1'b0,64'h0,   1'b0,64'h0,   1'b0, 64'h2,    64'h40},   // R7 jump R9
    '{4'd8, 64'h80,  64'h49,  1'b0,1'b0,64'h0,   1'b0,64'h0,   1'b0, 64'h40,   64'h80},   // R7 call
    '{4'd9, 64'h999, 64'h81,  1'b0,1'b0,64'h0,   1'b0,64'h0,   1'b1, 64'h80,   64'h81},   // R8 return, R10 stall
    '{4'd0, 64'h0,   64'h82,  1'b0,1'b0,64'h0,   1'b0,64'h0,   1'b0, 64'h80,   64'h82},   // R10 held
    '{4'd3, 64'h5,   64'hC,   1'b1,1'b0,64'hB,   1'b0,64'h0,   1'b0, 64'hB,    64'hC},    // R3
    '{4'd7, 64'h300, 64'h1D9, 1'b0,1'b0,64'h0,   1'b1,64'h1D0, 1'b0, 64'hC,    64'h300},  // placeholder fixed below
    '{4'd1, 64'h0,   64'h5F,  1'b1,1'b0,64'h55,  1'b1,64'h77,  1'b0, 64'h55,   64'h5F},   // R5
    '{4'd2, 64'h1,   64'h61,  1'b1,1'b1,64'h999, 1'b0,64'h0,   1'b0, 64'h5F,   64'h61},   // R6
    '{4'd8, 64'hFFFF_FFFF_FFFF_FFF0, 64'h6A, 1'b0,1'b0,64'h0, 1'b0,64'h0, 1'b0, 64'h61, 64'hFFFF_FFFF_FFFF_FFF0},
    '{4'd0, 64'h0,   64'h1235,1'b1,1'b0,64'h1234,1'b0,64'h0,   1'b1, 64'h1234, 64'h1235}, // R10 with fix
    '{4'd0, 64'h0,   64'h10,  1'b0,1'b0,64'h0,   1'b0,64'h0,   1'b0, 64'hFFFF_FFFF_FFFF_FFF0, 64'h10}
  };

  logic             clk;
  logic             rst_n;
  logic             f_stall;
  logic [CLS_W-1:0] f_cls;
  logic [PC_W-1:0]  f_valc, f_valp, m_fallthru, w_ret_addr;
  logic             m_cjmp, m_cnd, w_ret;
  logic [PC_W-1:0]  fetch_pc, pred_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fetch_pc_sel i_fetch_pc_sel (
    .clk(clk), .rst_n(rst_n), .f_stall(f_stall), .f_cls(f_cls),
    .f_valc(f_valc), .f_valp(f_valp), .m_cjmp(m_cjmp), .m_cnd(m_cnd),
    .m_fallthru(m_fallthru), .w_ret(w_ret), .w_ret_addr(w_ret_addr),
    .fetch_pc(fetch_pc), .pred_pc(pred_pc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    f_cls = v.cls; f_valc = v.valc; f_valp = v.valp;
    m_cjmp = v.mj; m_cnd = v.mc; m_fallthru = v.mf;
    w_ret = v.wr; w_ret_addr = v.wa; f_stall = v.st;
  endtask

  initial begin
    vec_t v;
    rst_n = 1'b1;
    apply('0);
    #2 rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset fetch", fetch_pc, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset released while pred_pc was 0, register still reads 0
    check("R1 after release", fetch_pc, 64'h0);
    for (int i = 0; i < NV; i++) begin
      v = TBL[i];
      if (i == 6) v.ef = 64'h1D0;   // R4: return overrides held C
      apply(v);
      #1;
      check($sformatf("R2-R6 fetch row %0d", i), fetch_pc, v.ef);
      check($sformatf("R7/R8 guess row %0d", i), pred_pc, v.ep);
      @(negedge clk);
    end
    // R9: row 11 loaded 0x10
    apply('0);
    f_valp = 64'h20;
    #1;
    check("R9 loaded guess", fetch_pc, 64'h10);
    // R8: all-ones class code uses valp
    f_cls = 4'hF; f_valc = 64'hAAAA; f_valp = 64'hBBBB;
    #1;
    check("R8 class 15", pred_pc, 64'hBBBB);
    // R1: mid-run asynchronous reset
    #1 rst_n = 1'b0;
    #1;
    check("R1 async reset", fetch_pc, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule